// File: doc/BRIEF.md
# I2C Bus Status Flag Logic

This block sits beside an I2C engine and watches already-synchronized SCL and SDA samples together with the engine's current role. It recognises START and STOP conditions and counts the clock pulses of each byte. From these it keeps four sticky status flags: arbitration lost, bus error, acknowledge failure and general-call match. It also holds the fast/standard speed selection bit.

The engine reads the flags through its status path and clears the error flags with a single-cycle read strobe. The block returns three controls to the engine. An interrupt request reports error flags. A one-cycle pulse forces the engine back to slave mode. An SCL-hold permission is withdrawn whenever an error flag is set, so the engine never stretches the clock while an error is pending.

SCL pulses are counted on rising edges after each START. A condition that appears during the first SCL-high phase after a byte boundary is treated as a legal boundary condition (repeated START or STOP). Any condition from the second clock pulse through the acknowledge pulse is misplaced.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset, every flag, the interrupt request, the slave-return pulse, the hold permission and the speed bit read 0.
- R2: The arbitration flag sets one clock after an SCL rising edge for data bits 1 to 8, when `master_i`=1, `sda_drive_i`=1 and `sda_i`=0. It does not set in slave mode, and it does not set on the acknowledge (ninth) pulse.
- R3: `to_slave_o` is high for exactly one cycle, in the cycle after each event that sets the arbitration or bus-error flag.
- R4: A START or STOP seen while SCL is high, from the second clock pulse of a byte through the acknowledge pulse, sets the bus-error flag.
- R5: A misplaced START sets the arbitration flag in the same cycle as the bus-error flag.
- R6: A misplaced STOP during the acknowledge pulse (the ninth SCL high phase) also sets the acknowledge-failure flag.
- R7: A START or STOP outside the byte window raises no flag. This covers the bus idle, a repeated START and a STOP right after the acknowledge pulse. A STOP ends the transfer.
- R8: A high `sr2_rd_i` clears the arbitration, bus-error and acknowledge-failure flags; a new set event in the same cycle wins. While `pe_i`=0, all four flags are held at 0 and cannot be set.
- R9: `scl_hold_en_o` is 1 only when `pe_i`=1 and neither the arbitration flag nor the bus-error flag is set.
- R10: `irq_o` is 1 when `ite_i`=1 and either the arbitration flag or the bus-error flag is set.
- R11: The general-call flag sets when `addr_match_i`=1, `gc_en_i`=1 and `pe_i`=1. It clears on a STOP, which wins over a same-cycle match, and when `pe_i`=0.
- R12: The speed bit `fm_o` loads `fm_d_i` on `fm_wr_i`, is changed only by a write or reset, and is unaffected by `pe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| pe_i | input | 1 | Peripheral enable |
| ite_i | input | 1 | Interrupt enable |
| gc_en_i | input | 1 | General-call enable |
| master_i | input | 1 | Engine is in master mode |
| sda_drive_i | input | 1 | Value the master drives on SDA (1 = released) |
| addr_match_i | input | 1 | Address-match strobe from the comparator |
| sr2_rd_i | input | 1 | Read strobe of the second status register |
| fm_wr_i | input | 1 | Write strobe for the speed bit |
| fm_d_i | input | 1 | Speed bit write data (1 = fast) |
| arlo_o | output | 1 | Arbitration-lost flag |
| berr_o | output | 1 | Bus-error flag |
| af_o | output | 1 | Acknowledge-failure flag |
| gcal_o | output | 1 | General-call match flag |
| irq_o | output | 1 | Interrupt request |
| to_slave_o | output | 1 | One-cycle pulse returning the engine to slave mode |
| scl_hold_en_o | output | 1 | Permission for the engine to hold SCL low |
| fm_o | output | 1 | Fast/standard speed bit |

## Verification
The hardest case to reach is a STOP during the acknowledge pulse. The bench must clock exactly eight data bits, raise SCL for the ninth pulse with SDA low, and then release SDA while SCL stays high. A single miscounted edge moves the event into the boundary window, where it is legal.

The bench drives the bus at the bit level through START, bit and STOP tasks. Misplaced conditions are injected after a chosen number of bits. A behavioural model tracks the pulse count and compares every output on every clock.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_stat_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.rise  = scl_i & ~scl_q;
    ev_o.fall  = ~scl_i & scl_q;
    ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
    ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_bit_track.sv
module i2c_bit_track
  import i2c_stat_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pe_i,
  input  bus_ev_t ev_i,
  output logic    in_byte_o,
  output logic    ack_phase_o,
  output logic    data_bit_o
);
  localparam int ACK_IDX = BYTE_BITS + 1;
  localparam int CNT_W   = $clog2(ACK_IDX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!pe_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (ev_i.start) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (ev_i.stop) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (ev_i.rise && act_q && cnt_q != CNT_W'(ACK_IDX)) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (ev_i.fall && cnt_q == CNT_W'(ACK_IDX)) begin
      cnt_q <= '0;
    end
  end

  // first high phase after a boundary may carry a legal START/STOP
  assign in_byte_o   = cnt_q >= CNT_W'(2);
  assign ack_phase_o = cnt_q == CNT_W'(ACK_IDX);
  assign data_bit_o  = act_q && (cnt_q < CNT_W'(BYTE_BITS));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(ACK_IDX));

  // R7
  stop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.stop |=> !act_q && cnt_q == '0);
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pe_i,
  input  logic ite_i,
  input  logic gc_en_i,
  input  logic master_i,
  input  logic sda_drive_i,
  input  logic sda_i,
  input  logic addr_match_i,
  input  logic sr2_rd_i,
  input  logic fm_wr_i,
  input  logic fm_d_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic rise_i,
  input  logic in_byte_i,
  input  logic ack_phase_i,
  input  logic data_bit_i,
  output logic arlo_o,
  output logic berr_o,
  output logic af_o,
  output logic gcal_o,
  output logic irq_o,
  output logic to_slave_o,
  output logic scl_hold_en_o,
  output logic fm_o
);
  logic arlo_q, berr_q, af_q, gcal_q, to_slave_q, fm_q;
  logic arlo_s, berr_s, af_s;

  assign arlo_s = pe_i & ((start_i & in_byte_i) |
                          (rise_i & data_bit_i & master_i & sda_drive_i & ~sda_i));
  assign berr_s = pe_i & (start_i | stop_i) & in_byte_i;
  assign af_s   = pe_i & stop_i & ack_phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arlo_q     <= 1'b0;
      berr_q     <= 1'b0;
      af_q       <= 1'b0;
      gcal_q     <= 1'b0;
      to_slave_q <= 1'b0;
    end else if (!pe_i) begin
      arlo_q     <= 1'b0;
      berr_q     <= 1'b0;
      af_q       <= 1'b0;
      gcal_q     <= 1'b0;
      to_slave_q <= 1'b0;
    end else begin
      arlo_q     <= arlo_s | (arlo_q & ~sr2_rd_i);
      berr_q     <= berr_s | (berr_q & ~sr2_rd_i);
      af_q       <= af_s   | (af_q   & ~sr2_rd_i);
      gcal_q     <= ~stop_i & (gcal_q | (addr_match_i & gc_en_i));
      to_slave_q <= arlo_s | berr_s;
    end
  end

  // speed bit survives disable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fm_q <= 1'b0;
    else if (fm_wr_i) fm_q <= fm_d_i;
  end

  assign arlo_o        = arlo_q;
  assign berr_o        = berr_q;
  assign af_o          = af_q;
  assign gcal_o        = gcal_q;
  assign to_slave_o    = to_slave_q;
  assign fm_o          = fm_q;
  assign irq_o         = ite_i & (arlo_q | berr_q);
  assign scl_hold_en_o = pe_i & ~(arlo_q | berr_q);

  // R3
  slave_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arlo_q) |-> to_slave_q);
  // R6
  af_with_berr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_q) |-> berr_q);
  // R8
  pe_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_i |=> !(arlo_q || berr_q || af_q || gcal_q));
  // R10
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(berr_q) && ite_i |-> irq_o);
  // R12
  fm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fm_wr_i |=> $stable(fm_q));
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_stat_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pe_i,
  input  logic ite_i,
  input  logic gc_en_i,
  input  logic master_i,
  input  logic sda_drive_i,
  input  logic addr_match_i,
  input  logic sr2_rd_i,
  input  logic fm_wr_i,
  input  logic fm_d_i,
  output logic arlo_o,
  output logic berr_o,
  output logic af_o,
  output logic gcal_o,
  output logic irq_o,
  output logic to_slave_o,
  output logic scl_hold_en_o,
  output logic fm_o
);
  bus_ev_t ev;
  logic    in_byte, ack_phase, data_bit;

  i2c_cond_detect u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .ev_o   (ev)
  );

  i2c_bit_track #(.BYTE_BITS(BYTE_BITS)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pe_i        (pe_i),
    .ev_i        (ev),
    .in_byte_o   (in_byte),
    .ack_phase_o (ack_phase),
    .data_bit_o  (data_bit)
  );

  i2c_flag_regs u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pe_i          (pe_i),
    .ite_i         (ite_i),
    .gc_en_i       (gc_en_i),
    .master_i      (master_i),
    .sda_drive_i   (sda_drive_i),
    .sda_i         (sda_i),
    .addr_match_i  (addr_match_i),
    .sr2_rd_i      (sr2_rd_i),
    .fm_wr_i       (fm_wr_i),
    .fm_d_i        (fm_d_i),
    .start_i       (ev.start),
    .stop_i        (ev.stop),
    .rise_i        (ev.rise),
    .in_byte_i     (in_byte),
    .ack_phase_i   (ack_phase),
    .data_bit_i    (data_bit),
    .arlo_o        (arlo_o),
    .berr_o        (berr_o),
    .af_o          (af_o),
    .gcal_o        (gcal_o),
    .irq_o         (irq_o),
    .to_slave_o    (to_slave_o),
    .scl_hold_en_o (scl_hold_en_o),
    .fm_o          (fm_o)
  );
endmodule

// File: tb/i2c_status_flags_tb.sv
module i2c_status_flags_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic scl = 1, sda = 1, pe = 0, ite = 0, gc_en = 0, master = 0, drv = 0;
  logic match = 0, rd = 0, fm_wr = 0, fm_d = 0;
  logic arlo, berr, af, gcal, irq, to_slave, hold_en, fm;

  i2c_status_flags u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda), .pe_i(pe),
    .ite_i(ite), .gc_en_i(gc_en), .master_i(master), .sda_drive_i(drv),
    .addr_match_i(match), .sr2_rd_i(rd), .fm_wr_i(fm_wr), .fm_d_i(fm_d),
    .arlo_o(arlo), .berr_o(berr), .af_o(af), .gcal_o(gcal), .irq_o(irq),
    .to_slave_o(to_slave), .scl_hold_en_o(hold_en), .fm_o(fm)
  );

  int n_tests = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  // behavioural reference
  logic m_arlo, m_berr, m_af, m_gcal, m_ts, m_fm, m_act, pscl, psda;
  int   m_cnt;
  logic e_rise, e_fall, e_st, e_sp, s_arlo, s_berr, s_af;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_arlo <= 0; m_berr <= 0; m_af <= 0; m_gcal <= 0; m_ts <= 0; m_fm <= 0;
      m_act <= 0; m_cnt <= 0; pscl <= 1; psda <= 1;
    end else begin
      e_rise = scl && !pscl;
      e_fall = !scl && pscl;
      e_st   = scl && pscl && psda && !sda;
      e_sp   = scl && pscl && !psda && sda;
      s_arlo = (e_st && m_cnt >= 2) ||
               (e_rise && m_act && m_cnt < 8 && master && drv && !sda);
      s_berr = (e_st || e_sp) && m_cnt >= 2;
      s_af   = e_sp && m_cnt == 9;
      pscl <= scl; psda <= sda;
      if (fm_wr) m_fm <= fm_d;
      if (!pe) begin
        m_arlo <= 0; m_berr <= 0; m_af <= 0; m_gcal <= 0; m_ts <= 0;
        m_act <= 0; m_cnt <= 0;
      end else begin
        m_arlo <= s_arlo || (m_arlo && !rd);
        m_berr <= s_berr || (m_berr && !rd);
        m_af   <= s_af   || (m_af && !rd);
        m_gcal <= e_sp ? 1'b0 : (m_gcal || (match && gc_en));
        m_ts   <= s_arlo || s_berr;
        if (e_st) begin m_cnt <= 0; m_act <= 1; end
        else if (e_sp) begin m_cnt <= 0; m_act <= 0; end
        else if (e_rise && m_act && m_cnt < 9) m_cnt <= m_cnt + 1;
        else if (e_fall && m_cnt == 9) m_cnt <= 0;
      end
    end
  end

  task automatic check(input string tag, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    check("R2 arlo vs model", arlo, m_arlo);
    check("R4 berr vs model", berr, m_berr);
    check("R6 af vs model", af, m_af);
    check("R11 gcal vs model", gcal, m_gcal);
    check("R3 to_slave vs model", to_slave, m_ts);
    check("R10 irq vs model", irq, ite && (m_arlo || m_berr));
    check("R9 hold vs model", hold_en, pe && !(m_arlo || m_berr));
    check("R12 fm vs model", fm, m_fm);
    if (to_slave) pulses++;
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic bus_start();
    sda = 1; step(2); scl = 1; step(2); sda = 0; step(2); scl = 0; step(2);
  endtask
  task automatic bus_stop();
    scl = 0; step(2); sda = 0; step(2); scl = 1; step(2); sda = 1; step(2);
  endtask
  task automatic bus_bit(input logic b);
    sda = b; step(2); scl = 1; step(3); scl = 0; step(2);
  endtask
  task automatic sr2_read();
    rd = 1; step(1); rd = 0; step(1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    step(3);
    // R1 reset state
    check("R1 arlo", arlo, 0); check("R1 berr", berr, 0); check("R1 af", af, 0);
    check("R1 gcal", gcal, 0); check("R1 irq", irq, 0); check("R1 to_slave", to_slave, 0);
    check("R1 hold", hold_en, 0); check("R1 fm", fm, 0);
    rst_ni = 1; step(2);

    // R12 speed bit survives disable
    fm_d = 1; fm_wr = 1; step(1); fm_wr = 0; fm_d = 0;
    pe = 1; step(2); pe = 0; step(3);
    check("R12 fm after disable", fm, 1);
    pe = 1; ite = 1; step(2);
    check("R9 hold with no flags", hold_en, 1);

    // R7 clean transfer, repeated start, stop after ack
    bus_start();
    for (int i = 0; i < 8; i++) bus_bit(i[0]);
    bus_bit(0);
    bus_start();
    for (int i = 0; i < 8; i++) bus_bit(~i[0]);
    bus_bit(0);
    bus_stop();
    check("R7 no berr on legal conditions", berr, 0);
    check("R7 no arlo on legal conditions", arlo, 0);

    // R2 slave mode ignores mismatch
    master = 0; drv = 1;
    bus_start(); bus_bit(1); bus_bit(0);
    check("R2 no arlo in slave mode", arlo, 0);
    for (int i = 0; i < 6; i++) bus_bit(1);
    bus_bit(0); bus_stop();

    // R2 ack pulse low while master released: no loss
    master = 1; drv = 1;
    bus_start();
    for (int i = 0; i < 8; i++) bus_bit(1);
    bus_bit(0);
    check("R2 no arlo on ack pulse", arlo, 0);
    bus_stop();

    // R2/R3/R10 arbitration lost at bit 3
    p0 = pulses;
    bus_start(); bus_bit(1); bus_bit(1); bus_bit(0);
    check("R2 arlo set", arlo, 1);
    check("R3 one slave pulse", (pulses - p0) == 1, 1);
    check("R10 irq on arlo", irq, 1);
    check("R9 hold dropped", hold_en, 0);
    master = 0; drv = 0;
    for (int i = 0; i < 5; i++) bus_bit(1);
    bus_bit(0); bus_stop();
    sr2_read();
    check("R8 arlo cleared by read", arlo, 0);
    check("R9 hold back", hold_en, 1);

    // R5 misplaced start mid byte
    p0 = pulses;
    bus_start(); bus_bit(1); bus_bit(0); bus_bit(1);
    bus_start();
    check("R5 berr on misplaced start", berr, 1);
    check("R5 arlo with misplaced start", arlo, 1);
    check("R3 single pulse for combined event", (pulses - p0) == 1, 1);
    bus_stop(); sr2_read();

    // R4 misplaced stop mid byte
    bus_start(); bus_bit(0); bus_bit(1); bus_bit(1);
    ite = 0;
    bus_stop();
    check("R4 berr on misplaced stop", berr, 1);
    check("R4 no arlo on stop", arlo, 0);
    check("R10 irq masked", irq, 0);
    ite = 1; step(1);
    check("R10 irq unmasked", irq, 1);
    sr2_read();
    check("R8 berr cleared by read", berr, 0);

    // R6 stop on ack pulse
    bus_start();
    for (int i = 0; i < 8; i++) bus_bit(1);
    sda = 0; step(2); scl = 1; step(2); sda = 1; step(2);
    check("R6 af on ack stop", af, 1);
    check("R6 berr on ack stop", berr, 1);
    // R8 disable clears
    pe = 0; step(2);
    check("R8 af cleared by disable", af, 0);
    check("R8 berr cleared by disable", berr, 0);
    pe = 1; step(2);

    // R11 general call
    gc_en = 0; match = 1; step(1); match = 0; step(1);
    check("R11 no gcal without enable", gcal, 0);
    gc_en = 1; match = 1; step(1); match = 0; step(1);
    check("R11 gcal set", gcal, 1);
    bus_start(); bus_stop();
    check("R11 gcal cleared by stop", gcal, 0);
    match = 1; step(1); match = 0; pe = 0; step(1);
    check("R11 gcal cleared by disable", gcal, 0);
    pe = 1; step(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule